// File: doc/BRIEF.md
# Posted Programmed-I/O Write Buffer

This block sits between a 128-bit system bus and a 32-bit I/O bus and carries programmed-I/O writes from a processor to an I/O target. A system-side write of one or two 16-byte beats is captured into a single 32-byte buffer. The write is reported complete to the processor as soon as its last beat is held in the buffer. The processor does not wait for the I/O target. The block then empties the buffer on its own. It issues one address phase on the I/O bus, followed by a burst of 32-bit data beats, each with its own byte enables.

Both sides use valid/ready handshakes on one shared clock. While the buffer holds data that has not yet left, the system side sees ready low. The capture side uses three states. CAP_IDLE waits for a first beat. It moves to CAP_NEXT after the first beat of a two-beat write, or straight to CAP_FULL after a one-beat write. CAP_NEXT moves to CAP_FULL when the final beat is accepted. CAP_FULL returns to CAP_IDLE when the last I/O data beat is accepted. The drain side also uses three states. DRN_IDLE moves to DRN_ADDR when the buffer is full. DRN_ADDR moves to DRN_DATA on the address handshake. DRN_DATA returns to DRN_IDLE on the handshake of the final data beat.

Top module: `pio_post_wbuf`

## Requirements
- R1: After reset, sys_ready is 1 and sys_done, io_addr_valid and io_dvalid are 0.
- R2: sys_ready is 1 while the buffer is empty and between the two beats of a two-beat write. A beat is captured on every cycle in which sys_valid and sys_ready are both 1.
- R3: sys_done is 1 for exactly one cycle: the cycle right after the final system beat is captured. This happens before any I/O beat has been sent.
- R4: From the capture of the final system beat until the cycle after the last I/O data beat is accepted, sys_ready is 0. Beats offered during that time are not captured and do not change the data sent on the I/O bus.
- R5: Exactly one address phase is issued per write. io_addr_valid stays 1 with io_addr unchanged until io_addr_ready is 1. io_addr is the captured address with its low 4 bits cleared. io_beats equals 4 times the number of system beats.
- R6: No data beat is presented before the address handshake has completed.
- R7: I/O data beat k carries bits [32*(k mod 4) +: 32] of system beat k/4, and byte enables bits [4*(k mod 4) +: 4] of that beat's enables. Beats go out in increasing address order.
- R8: A data beat whose byte enables are all zero is still presented and counted, so a two-beat write always yields 8 data beats and a one-beat write yields 4.
- R9: Once presented, io_dvalid stays 1 with io_data and io_be unchanged until io_dready is 1.
- R10: io_dlast is 1 on the final data beat of the burst and on no other beat.
- R11: sys_len is read only with the first beat: 0 means one system beat and 1 means two. Its value on a second beat has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_valid | input | 1 | System beat valid |
| sys_ready | output | 1 | Buffer can take a system beat |
| sys_addr | input | 32 | Write address, sampled with the first beat |
| sys_len | input | 1 | Beats in the write minus one, sampled with the first beat |
| sys_data | input | 128 | System beat data |
| sys_be | input | 16 | System beat byte enables |
| sys_done | output | 1 | One-cycle completion pulse to the issuer |
| io_addr_valid | output | 1 | I/O address phase valid |
| io_addr_ready | input | 1 | I/O target accepts the address |
| io_addr | output | 32 | Burst start address (16-byte aligned) |
| io_beats | output | 4 | Number of data beats in the burst |
| io_dvalid | output | 1 | I/O data beat valid |
| io_dready | input | 1 | I/O target accepts the data beat |
| io_data | output | 32 | I/O data beat |
| io_be | output | 4 | I/O beat byte enables |
| io_dlast | output | 1 | Final data beat of the burst |

## Verification
The hardest situation to reach from the ports is a processor that keeps offering a new write while the previous one is still draining under I/O backpressure. That is the only moment when a wrongly raised ready would corrupt the buffer. The stimulus holds sys_valid high with all-ones junk data during every address phase. It sweeps each write length against four stall patterns on the address and data handshakes. Every drained beat is then compared with words computed from the write's seed, so any leaked junk beat shows up as a data mismatch.

// File: rtl/pio_wbuf_pkg.sv
package pio_wbuf_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_NEXT = 2'd1,
        CAP_FULL = 2'd2
    } cap_state_t;

    typedef enum logic [1:0] {
        DRN_IDLE = 2'd0,
        DRN_ADDR = 2'd1,
        DRN_DATA = 2'd2
    } drn_state_t;

endpackage

// File: rtl/pio_wbuf_capture.sv
module pio_wbuf_capture
    import pio_wbuf_pkg::*;
#(
    parameter int SYS_W  = 128,
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 2,
    parameter int LEN_W  = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sys_valid,
    output logic                    sys_ready,
    input  logic [ADDR_W-1:0]       sys_addr,
    input  logic [LEN_W-1:0]        sys_len,
    input  logic [SYS_W-1:0]        sys_data,
    input  logic [SYS_W/8-1:0]      sys_be,
    output logic                    sys_done,
    input  logic                    drain_finish,
    output logic                    buf_full,
    output logic [ADDR_W-1:0]       buf_addr,
    output logic [LEN_W-1:0]        buf_last,
    output logic [SLOTS*SYS_W-1:0]  buf_data,
    output logic [SLOTS*SYS_W/8-1:0] buf_be
);

    localparam int BE_W  = SYS_W / 8;
    localparam int OFF_W = $clog2(BE_W);

    cap_state_t         state_q, state_d;
    logic [LEN_W-1:0]   slot_q;
    logic [LEN_W-1:0]   last_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               done_q;
    logic               accept;
    logic               final_beat;
    logic [LEN_W-1:0]   wr_idx;

    assign accept = sys_valid && sys_ready;
    assign wr_idx = (state_q == CAP_IDLE) ? '0 : slot_q;

    // next-state logic
    always_comb begin
        state_d    = state_q;
        final_beat = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (accept) begin
                    final_beat = (sys_len == '0);
                    state_d    = final_beat ? CAP_FULL : CAP_NEXT;
                end
            end
            CAP_NEXT: begin
                if (accept && (slot_q == last_q)) begin
                    final_beat = 1'b1;
                    state_d    = CAP_FULL;
                end
            end
            CAP_FULL: begin
                if (drain_finish) begin
                    state_d = CAP_IDLE;
                end
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= final_beat;
        end
    end

    // header and slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            last_q <= '0;
            addr_q <= '0;
        end else if (accept) begin
            if (state_q == CAP_IDLE) begin
                addr_q <= sys_addr;
                last_q <= sys_len;
                slot_q <= LEN_W'(1);
            end else begin
                slot_q <= slot_q + LEN_W'(1);
            end
        end
    end

    // one storage slot per system beat
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [SYS_W-1:0] data_q;
        logic [BE_W-1:0]  be_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                be_q   <= '0;
            end else if (accept && (wr_idx == LEN_W'(g))) begin
                data_q <= sys_data;
                be_q   <= sys_be;
            end
        end
        assign buf_data[g*SYS_W +: SYS_W] = data_q;
        assign buf_be[g*BE_W +: BE_W]     = be_q;
    end

    // outputs
    always_comb begin
        sys_ready = (state_q != CAP_FULL);
        buf_full  = (state_q == CAP_FULL);
        sys_done  = done_q;
        buf_last  = last_q;
        buf_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        sys_done |=> !sys_done);

    a_r2_ready_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (state_q == CAP_IDLE) && (sys_len != '0)) |=> sys_ready);

    a_r4_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sys_done |-> !sys_ready);

endmodule

// File: rtl/pio_wbuf_drain.sv
module pio_wbuf_drain
    import pio_wbuf_pkg::*;
#(
    parameter int SYS_W  = 128,
    parameter int IO_W   = 32,
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 2,
    parameter int LEN_W  = 1,
    parameter int CNT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_full,
    input  logic [ADDR_W-1:0]        buf_addr,
    input  logic [LEN_W-1:0]         buf_last,
    input  logic [SLOTS*SYS_W-1:0]   buf_data,
    input  logic [SLOTS*SYS_W/8-1:0] buf_be,
    output logic                     drain_finish,
    output logic                     io_addr_valid,
    input  logic                     io_addr_ready,
    output logic [ADDR_W-1:0]        io_addr,
    output logic [CNT_W-1:0]         io_beats,
    output logic                     io_dvalid,
    input  logic                     io_dready,
    output logic [IO_W-1:0]          io_data,
    output logic [IO_W/8-1:0]        io_be,
    output logic                     io_dlast
);

    localparam int LANES     = SYS_W / IO_W;
    localparam int TOTAL_MAX = SLOTS * LANES;
    localparam int IDX_W     = $clog2(TOTAL_MAX);
    localparam int IO_BE_W   = IO_W / 8;

    drn_state_t         state_q, state_d;
    logic [IDX_W-1:0]   idx_q;
    logic [CNT_W-1:0]   beat_cnt;
    logic [IDX_W-1:0]   last_idx;
    logic               on_last;

    logic [IO_W-1:0]    words [TOTAL_MAX];
    logic [IO_BE_W-1:0] enables [TOTAL_MAX];

    // flat buffer is slot-major, so beat k sits at word k
    for (genvar k = 0; k < TOTAL_MAX; k++) begin : g_word
        assign words[k]   = buf_data[k*IO_W +: IO_W];
        assign enables[k] = buf_be[k*IO_BE_W +: IO_BE_W];
    end

    assign beat_cnt = CNT_W'((int'(buf_last) + 1) * LANES);
    assign last_idx = IDX_W'(beat_cnt - CNT_W'(1));
    assign on_last  = (idx_q == last_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRN_IDLE: if (buf_full)                state_d = DRN_ADDR;
            DRN_ADDR: if (io_addr_ready)           state_d = DRN_DATA;
            DRN_DATA: if (io_dready && on_last)    state_d = DRN_IDLE;
            default:                               state_d = DRN_IDLE;
        endcase
    end

    // state register and beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DRN_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DRN_ADDR) begin
                idx_q <= '0;
            end else if ((state_q == DRN_DATA) && io_dready) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        io_addr_valid = (state_q == DRN_ADDR);
        io_addr       = buf_addr;
        io_beats      = beat_cnt;
        io_dvalid     = (state_q == DRN_DATA);
        io_data       = words[idx_q];
        io_be         = enables[idx_q];
        io_dlast      = (state_q == DRN_DATA) && on_last;
        drain_finish  = (state_q == DRN_DATA) && io_dready && on_last;
    end

    a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr_valid && !io_addr_ready) |=> (io_addr_valid && $stable(io_addr)));

    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (io_dvalid && !io_dready) |=> (io_dvalid && $stable(io_data) && $stable(io_be)));

    a_r10_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        io_dlast |-> io_dvalid);

endmodule

// File: rtl/pio_post_wbuf.sv
module pio_post_wbuf #(
    parameter int SYS_W     = 128,
    parameter int IO_W      = 32,
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sys_valid,
    output logic                sys_ready,
    input  logic [ADDR_W-1:0]   sys_addr,
    input  logic [((BUF_BYTES/(SYS_W/8)) > 1 ? $clog2(BUF_BYTES/(SYS_W/8)) : 1)-1:0] sys_len,
    input  logic [SYS_W-1:0]    sys_data,
    input  logic [SYS_W/8-1:0]  sys_be,
    output logic                sys_done,
    output logic                io_addr_valid,
    input  logic                io_addr_ready,
    output logic [ADDR_W-1:0]   io_addr,
    output logic [$clog2(BUF_BYTES/(IO_W/8))+1-1:0] io_beats,
    output logic                io_dvalid,
    input  logic                io_dready,
    output logic [IO_W-1:0]     io_data,
    output logic [IO_W/8-1:0]   io_be,
    output logic                io_dlast
);

    localparam int SLOTS = BUF_BYTES / (SYS_W / 8);
    localparam int LEN_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(BUF_BYTES / (IO_W / 8)) + 1;

    logic                     buf_full;
    logic                     drain_finish;
    logic [ADDR_W-1:0]        buf_addr;
    logic [LEN_W-1:0]         buf_last;
    logic [SLOTS*SYS_W-1:0]   buf_data;
    logic [SLOTS*SYS_W/8-1:0] buf_be;

    pio_wbuf_capture #(
        .SYS_W  (SYS_W),
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS),
        .LEN_W  (LEN_W)
    ) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .sys_valid    (sys_valid),
        .sys_ready    (sys_ready),
        .sys_addr     (sys_addr),
        .sys_len      (sys_len),
        .sys_data     (sys_data),
        .sys_be       (sys_be),
        .sys_done     (sys_done),
        .drain_finish (drain_finish),
        .buf_full     (buf_full),
        .buf_addr     (buf_addr),
        .buf_last     (buf_last),
        .buf_data     (buf_data),
        .buf_be       (buf_be)
    );

    pio_wbuf_drain #(
        .SYS_W  (SYS_W),
        .IO_W   (IO_W),
        .ADDR_W (ADDR_W),
        .SLOTS  (SLOTS),
        .LEN_W  (LEN_W),
        .CNT_W  (CNT_W)
    ) u_drain (
        .clk           (clk),
        .rst_n         (rst_n),
        .buf_full      (buf_full),
        .buf_addr      (buf_addr),
        .buf_last      (buf_last),
        .buf_data      (buf_data),
        .buf_be        (buf_be),
        .drain_finish  (drain_finish),
        .io_addr_valid (io_addr_valid),
        .io_addr_ready (io_addr_ready),
        .io_addr       (io_addr),
        .io_beats      (io_beats),
        .io_dvalid     (io_dvalid),
        .io_dready     (io_dready),
        .io_data       (io_data),
        .io_be         (io_be),
        .io_dlast      (io_dlast)
    );

    a_r4_busy_while_drain: assert property (@(posedge clk) disable iff (!rst_n)
        io_dvalid |-> !sys_ready);

    a_r6_addr_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        io_addr_valid |-> !io_dvalid);

    a_r4_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (io_dvalid && io_dready && io_dlast) |=> sys_ready);

endmodule

// File: tb/pio_post_wbuf_tb.sv
module pio_post_wbuf_tb;

    localparam int LANES = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         sys_valid;
    logic         sys_ready;
    logic [31:0]  sys_addr;
    logic [0:0]   sys_len;
    logic [127:0] sys_data;
    logic [15:0]  sys_be;
    logic         sys_done;
    logic         io_addr_valid;
    logic         io_addr_ready;
    logic [31:0]  io_addr;
    logic [3:0]   io_beats;
    logic         io_dvalid;
    logic         io_dready;
    logic [31:0]  io_data;
    logic [3:0]   io_be;
    logic         io_dlast;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    pio_post_wbuf u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sys_valid     (sys_valid),
        .sys_ready     (sys_ready),
        .sys_addr      (sys_addr),
        .sys_len       (sys_len),
        .sys_data      (sys_data),
        .sys_be        (sys_be),
        .sys_done      (sys_done),
        .io_addr_valid (io_addr_valid),
        .io_addr_ready (io_addr_ready),
        .io_addr       (io_addr),
        .io_beats      (io_beats),
        .io_dvalid     (io_dvalid),
        .io_dready     (io_dready),
        .io_data       (io_data),
        .io_be         (io_be),
        .io_dlast      (io_dlast)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int seed, int s, int l);
        return 32'(seed) * 32'h0100_0193 + 32'(s * LANES + l) * 32'h11 + 32'h5A00_0000;
    endfunction

    function automatic logic [3:0] exp_be(int seed, int s, int l);
        if ((seed % 3 == 0) && (l == 1)) return 4'h0;
        return 4'((seed * 5 + s * LANES + l) % 15 + 1);
    endfunction

    function automatic logic addr_rdy(int mode, int c);
        return (c >= mode);
    endfunction

    function automatic logic data_rdy(int mode, int c);
        case (mode)
            0:       return 1'b1;
            1:       return (c % 2 == 0);
            2:       return (c % 3 == 2);
            default: return (c % 4 != 1);
        endcase
    endfunction

    task automatic drive_beat(int seed, int s);
        for (int l = 0; l < LANES; l++) begin
            sys_data[32*l +: 32] = exp_word(seed, s, l);
            sys_be[4*l +: 4]     = exp_be(seed, s, l);
        end
    endtask

    task automatic run_txn(int seed);
        int len  = seed % 2;
        int mode = (seed / 2) % 4;
        int nio  = (len + 1) * LANES;
        int c;
        int k;
        bit got;
        logic [31:0] base = 32'(seed) * 32'h1000 + 32'h3B;

        @(negedge clk);
        check("R2 ready before first beat", 64'(sys_ready), 64'd1);
        sys_valid = 1'b1;
        sys_addr  = base;
        sys_len   = len[0];
        drive_beat(seed, 0);
        @(negedge clk);
        if (len == 1) begin
            check("R3 no completion before final beat", 64'(sys_done), 64'd0);
            check("R2 ready between beats", 64'(sys_ready), 64'd1);
            sys_addr = 32'hDEAD_BEE0;
            sys_len  = 1'b0;          // R11: ignored on second beat
            drive_beat(seed, 1);
            @(negedge clk);
        end
        check("R3 completion pulse", 64'(sys_done), 64'd1);
        check("R4 ready low once captured", 64'(sys_ready), 64'd0);
        check("R3 completion before I/O delivery", 64'(io_dvalid), 64'd0);
        // offer junk while the buffer is busy
        sys_valid = 1'b1;
        sys_data  = '1;
        sys_be    = '1;
        @(negedge clk);
        check("R3 completion lasts one cycle", 64'(sys_done), 64'd0);

        c = 0;
        got = 1'b0;
        while (!got && c < 50) begin
            io_addr_ready = addr_rdy(mode, c);
            check("R6 no data before address", 64'(io_dvalid), 64'd0);
            check("R4 junk not accepted", 64'(sys_ready), 64'd0);
            check("R5 address valid held", 64'(io_addr_valid), 64'd1);
            check("R5 aligned address", 64'(io_addr), 64'(base & 32'hFFFF_FFF0));
            check("R11 beat count from first length", 64'(io_beats), 64'(nio));
            if (io_addr_valid && io_addr_ready) got = 1'b1;
            @(negedge clk);
            c++;
        end
        io_addr_ready = 1'b0;
        sys_valid     = 1'b0;
        check("R5 address handshake", 64'(got), 64'd1);

        k = 0;
        c = 0;
        while (k < nio && c < 200) begin
            io_dready = data_rdy(mode, c);
            check("R4 ready low while draining", 64'(sys_ready), 64'd0);
            check("R9 data valid held", 64'(io_dvalid), 64'd1);
            check("R6 single address phase", 64'(io_addr_valid), 64'd0);
            if (io_dvalid) begin
                check("R7 beat data order", 64'(io_data), 64'(exp_word(seed, k / LANES, k % LANES)));
                if (exp_be(seed, k / LANES, k % LANES) == 4'h0)
                    check("R8 zero-enable beat sent", 64'(io_be), 64'h0);
                else
                    check("R7 beat enables", 64'(io_be), 64'(exp_be(seed, k / LANES, k % LANES)));
                check("R10 last flag", 64'(io_dlast), 64'(k == nio - 1));
                if (io_dready) k++;
            end
            @(negedge clk);
            c++;
        end
        io_dready = 1'b0;
        check("R8 beat count delivered", 64'(k), 64'(nio));
        check("R4 ready back after last beat", 64'(sys_ready), 64'd1);
        check("R10 burst ended", 64'(io_dvalid), 64'd0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        rst_n         = 1'b0;
        sys_valid     = 1'b0;
        sys_addr      = '0;
        sys_len       = '0;
        sys_data      = '0;
        sys_be        = '0;
        io_addr_ready = 1'b0;
        io_dready     = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset ready", 64'(sys_ready), 64'd1);
        check("R1 reset done", 64'(sys_done), 64'd0);
        check("R1 reset addr valid", 64'(io_addr_valid), 64'd0);
        check("R1 reset data valid", 64'(io_dvalid), 64'd0);
        rst_n = 1'b1;
        for (int seed = 0; seed < 16; seed++) begin
            run_txn(seed);
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule